// File: doc/BRIEF.md
# Ethernet Receive Statistics Counters

This block keeps two receive-side statistics for an Ethernet MAC. At the end of every received frame the MAC presents a one-cycle summary. The summary holds the frame length, a CRC-good flag and an address-match flag, together with the current receive-enable and long-frame-enable controls. The block uses the summary to update a jabber counter and a total received-octet counter. The frame length covers every byte from the first destination-address byte through the last CRC byte.

A jabber frame is an address-matched frame that is both too long and has a bad CRC. The length limit is 1522 bytes normally and 16384 bytes when long frames are enabled. The octet total adds the length of every address-matched frame, whatever the frame's size or error status. Both counters stop at all ones instead of wrapping.

Software reads the counters through a 32-bit port with a one-cycle read latency. Reading the jabber count clears it. The 64-bit octet total is split into a low word and a high word. Reading the high word clears the whole total. Software is expected to read the low word first.

Top module: `rxstat_counters`

## Requirements
- R1: After reset, both counters are zero, and a read at any address (0, 1 or 2) returns 0.
- R2: With long-frame-enable low, a bad-CRC matched frame of 1522 bytes does not count as jabber, and one of 1523 bytes does.
- R3: With long-frame-enable high, a bad-CRC matched frame of 16384 bytes or less does not count as jabber, and one of 16385 bytes does.
- R4: An oversized frame with a good CRC does not change the jabber count, and an undersized frame with a bad CRC does not change it either.
- R5: The octet total grows by the exact length of every address-matched frame, for good and bad CRC alike and for any length.
- R6: A frame with the address-match flag low changes neither counter.
- R7: While receive-enable is low, frames change neither counter.
- R8: The octet total stops at all ones and does not wrap; the high word holds bits 63:32 of the total and the low word holds bits 31:0.
- R9: A read at address 2 returns the high octet word, then clears the whole total. A read at address 1 returns the low word and has no side effect.
- R10: A read at address 0 returns the jabber count, then clears it. Read data appears on rd_data in the cycle after rd_en.
- R11: The jabber counter stops at all ones and does not wrap.
- R12: When a clearing read and a frame summary arrive in the same cycle, the read returns the value from before the frame. The counter then holds only that frame's contribution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle pulse: frame summary valid |
| frm_len | input | LEN_W | Frame length in bytes, destination address through CRC |
| frm_crc_ok | input | 1 | Frame CRC was good |
| frm_addr_match | input | 1 | Frame passed the address filter |
| rx_enable | input | 1 | Receive enabled |
| long_pkt_en | input | 1 | Raises the oversize limit from 1522 to 16384 bytes |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | 0 jabber, 1 octet low, 2 octet high, 3 reads zero |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
A wrong length limit or a wrong jabber qualifier leaves the jabber count off by one frame. That error shows at the very next read of address 0, one cycle after the read strobe. A lost carry, a missing saturation or a half-cleared octet total shows up as a wrong low or high word on the next pair of reads. The bench therefore reads both words at each threshold and clear boundary. It also reads immediately after clears that coincide with a frame summary, where a dropped or doubled event would be visible at once.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    localparam int unsigned STD_MAX_BYTES  = 1522;
    localparam int unsigned LONG_MAX_BYTES = 16384;

    typedef enum logic [1:0] {
        RA_JABBER = 2'd0,
        RA_OCT_LO = 2'd1,
        RA_OCT_HI = 2'd2,
        RA_NONE   = 2'd3
    } rd_addr_e;

    typedef struct packed {
        logic matched;
        logic crc_ok;
        logic rx_on;
        logic long_on;
    } frame_flags_t;

    typedef struct packed {
        logic jab_hit;
        logic oct_hit;
    } frame_verdict_t;

    function automatic logic is_oversize(input int unsigned len, input logic long_on);
        int unsigned limit;
        limit = long_on ? LONG_MAX_BYTES : STD_MAX_BYTES;
        return len > limit;
    endfunction

endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify
    import rxstat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             valid,
    input  logic [LEN_W-1:0] len,
    input  frame_flags_t     flags,
    output frame_verdict_t   verdict
);
    localparam int PAD_W = 32 - LEN_W;

    logic counted;
    logic big;

    always_comb begin
        counted = valid && flags.rx_on && flags.matched;
        big     = is_oversize({{PAD_W{1'b0}}, len}, flags.long_on);
        verdict.oct_hit = counted;
        verdict.jab_hit = counted && big && !flags.crc_ok;
    end

endmodule

// File: rtl/rxstat_sat_counter.sv
module rxstat_sat_counter #(
    parameter int W  = 32,
    parameter int AW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add_en,
    input  logic [AW-1:0] add_val,
    output logic [W-1:0]  cnt
);
    localparam int EXT_W = W + 1 - AW;

    logic [W-1:0] base;
    logic [W:0]   sum;
    logic [W-1:0] nxt;

    always_comb begin
        base = clr ? '0 : cnt;
        sum  = {1'b0, base} + {{EXT_W{1'b0}}, add_val};
        if (!add_en)
            nxt = base;
        else if (sum[W])
            nxt = '1;
        else
            nxt = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= nxt;
    end

    // R8 and R11: no wrap
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt));

    // R8 and R11: all ones holds
    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!clr && (&cnt)) |=> (&cnt));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !add_en) |=> cnt == '0);

endmodule

// File: rtl/rxstat_readport.sv
module rxstat_readport
    import rxstat_pkg::*;
#(
    parameter int JAB_W = 32,
    parameter int OCT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    input  logic [JAB_W-1:0] jab_cnt,
    input  logic [OCT_W-1:0] oct_cnt,
    output logic             clr_jab,
    output logic             clr_oct,
    output logic [31:0]      rd_data
);
    localparam int HI_W  = OCT_W - 32;
    localparam int JPAD  = 32 - JAB_W;
    localparam int HPAD  = 32 - HI_W;

    rd_addr_e     sel;
    logic [31:0]  word;

    always_comb begin
        sel     = rd_addr_e'(rd_addr);
        clr_jab = rd_en && (sel == RA_JABBER);
        clr_oct = rd_en && (sel == RA_OCT_HI);
        unique case (sel)
            RA_JABBER: word = {{JPAD{1'b0}}, jab_cnt};
            RA_OCT_LO: word = oct_cnt[31:0];
            RA_OCT_HI: word = {{HPAD{1'b0}}, oct_cnt[OCT_W-1:32]};
            default:   word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= word;
    end

    assert_lo_no_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 2'd1) |-> !clr_oct && !clr_jab);

endmodule

// File: rtl/rxstat_counters.sv
module rxstat_counters
    import rxstat_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int JAB_W = 32,
    parameter int OCT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_valid,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_crc_ok,
    input  logic             frm_addr_match,
    input  logic             rx_enable,
    input  logic             long_pkt_en,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data
);
    frame_flags_t   flags;
    frame_verdict_t verdict;
    logic           clr_jab;
    logic           clr_oct;
    logic [JAB_W-1:0] jab_cnt;
    logic [OCT_W-1:0] oct_cnt;

    always_comb begin
        flags.matched = frm_addr_match;
        flags.crc_ok  = frm_crc_ok;
        flags.rx_on   = rx_enable;
        flags.long_on = long_pkt_en;
    end

    rxstat_classify #(.LEN_W(LEN_W)) u_classify (
        .valid   (frm_valid),
        .len     (frm_len),
        .flags   (flags),
        .verdict (verdict)
    );

    rxstat_sat_counter #(.W(JAB_W), .AW(1)) u_jab (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_jab),
        .add_en  (verdict.jab_hit),
        .add_val (1'b1),
        .cnt     (jab_cnt)
    );

    rxstat_sat_counter #(.W(OCT_W), .AW(LEN_W)) u_oct (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_oct),
        .add_en  (verdict.oct_hit),
        .add_val (frm_len),
        .cnt     (oct_cnt)
    );

    rxstat_readport #(.JAB_W(JAB_W), .OCT_W(OCT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .jab_cnt (jab_cnt),
        .oct_cnt (oct_cnt),
        .clr_jab (clr_jab),
        .clr_oct (clr_oct),
        .rd_data (rd_data)
    );

    assert_good_crc_no_jab_R4: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_crc_ok && !rd_en) |=> $stable(jab_cnt));

    assert_unmatched_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_addr_match && !rd_en) |=> $stable(jab_cnt) && $stable(oct_cnt));

    assert_rx_off_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !rx_enable && !rd_en) |=> $stable(jab_cnt) && $stable(oct_cnt));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!frm_valid && !rd_en) |=> $stable(oct_cnt) && $stable(jab_cnt));

endmodule

// File: tb/sim_rxstat_counters.sv
`timescale 1ns/1ps
module sim_rxstat_counters;
    localparam int LW = 20;
    localparam int JW = 8;
    localparam int OW = 34;
    localparam longint unsigned OCT_MAX = (64'd1 << OW) - 64'd1;
    localparam longint unsigned JAB_MAX = (64'd1 << JW) - 64'd1;

    logic          clk = 1'b0;
    logic          rst;
    logic          frm_valid = 1'b0;
    logic [LW-1:0] frm_len = '0;
    logic          frm_crc_ok = 1'b0;
    logic          frm_addr_match = 1'b0;
    logic          rx_enable = 1'b0;
    logic          long_pkt_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = 2'd0;
    logic [31:0]   rd_data;

    int checks = 0;
    int fails  = 0;
    longint unsigned exp_jab = 0;
    longint unsigned exp_oct = 0;

    always #4 clk = ~clk;

    rxstat_counters #(.LEN_W(LW), .JAB_W(JW), .OCT_W(OW)) u0 (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_crc_ok(frm_crc_ok), .frm_addr_match(frm_addr_match),
        .rx_enable(rx_enable), .long_pkt_en(long_pkt_en),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input longint unsigned got, input longint unsigned exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic void model_frame(input int unsigned len, input bit crc, input bit m,
                                        input bit rx, input bit lpe);
        int unsigned lim;
        lim = lpe ? 16384 : 1522;
        if (m && rx) begin
            exp_oct = (exp_oct + len > OCT_MAX) ? OCT_MAX : exp_oct + len;
            if (!crc && len > lim && exp_jab < JAB_MAX)
                exp_jab++;
        end
    endfunction

    task automatic drive_frame(input int unsigned len, input bit crc, input bit m,
                               input bit rx, input bit lpe);
        frm_valid = 1'b1; frm_len = LW'(len); frm_crc_ok = crc;
        frm_addr_match = m; rx_enable = rx; long_pkt_en = lpe;
    endtask

    task automatic send_frame(input int unsigned len, input bit crc, input bit m,
                              input bit rx, input bit lpe);
        @(negedge clk);
        drive_frame(len, crc, m, rx, lpe);
        @(negedge clk);
        frm_valid = 1'b0;
        model_frame(len, crc, m, rx, lpe);
    endtask

    function automatic longint unsigned word_of(input int a);
        if (a == 0) return exp_jab;
        if (a == 1) return exp_oct & 64'hFFFF_FFFF;
        if (a == 2) return exp_oct >> 32;
        return 0;
    endfunction

    task automatic read_check(input string tag, input int a);
        longint unsigned e;
        e = word_of(a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {32'd0, rd_data}, e);
        if (a == 0) exp_jab = 0;
        if (a == 2) exp_oct = 0;
    endtask

    task automatic read_with_frame(input string tag, input int a, input int unsigned len,
                                   input bit crc, input bit lpe);
        longint unsigned e;
        e = word_of(a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'(a);
        drive_frame(len, crc, 1'b1, 1'b1, lpe);
        @(negedge clk);
        rd_en = 1'b0; frm_valid = 1'b0;
        check(tag, {32'd0, rd_data}, e);
        if (a == 0) exp_jab = 0;
        if (a == 2) exp_oct = 0;
        model_frame(len, crc, 1'b1, 1'b1, lpe);
    endtask

    task automatic t_reset();
        check("R1 rd_data after reset", {32'd0, rd_data}, 0);
        read_check("R1 jabber after reset", 0);
        read_check("R1 octet lo after reset", 1);
        read_check("R1 octet hi after reset", 2);
    endtask

    task automatic t_std_limit();
        send_frame(1522, 0, 1, 1, 0);
        read_check("R2 1522 bad crc not jabber", 0);
        send_frame(1523, 0, 1, 1, 0);
        check("R2 model expects one", exp_jab, 1);
        read_check("R2 1523 bad crc is jabber", 0);
        read_check("R5 octets after R2 frames", 1);
        read_check("R5 octet hi after R2 frames", 2);
    endtask

    task automatic t_long_limit();
        send_frame(1523, 0, 1, 1, 1);
        send_frame(16384, 0, 1, 1, 1);
        read_check("R3 16384 long mode not jabber", 0);
        send_frame(16385, 0, 1, 1, 1);
        read_check("R3 16385 long mode is jabber", 0);
    endtask

    task automatic t_qualifiers();
        send_frame(3000, 1, 1, 1, 0);
        send_frame(64, 0, 1, 1, 0);
        read_check("R4 good crc or short frame no jabber", 0);
        send_frame(3000, 0, 0, 1, 0);
        send_frame(500, 1, 0, 1, 0);
        read_check("R6 unmatched no jabber", 0);
        read_check("R6 unmatched no octets (hi clears)", 2);
        read_check("R6 lo zero after hi read", 1);
    endtask

    task automatic t_octets();
        send_frame(64, 1, 1, 1, 0);
        send_frame(1518, 0, 1, 1, 0);
        send_frame(20000, 0, 1, 1, 1);
        send_frame(9, 1, 1, 1, 1);
        check("R5 model octet sum", exp_oct, 64 + 1518 + 20000 + 9);
        read_check("R5 octet lo sum", 1);
        read_check("R9 octet lo read again unchanged", 1);
        read_check("R9 octet hi returns old", 2);
        read_check("R9 octet lo cleared by hi read", 1);
    endtask

    task automatic t_rx_off();
        send_frame(700, 1, 1, 1, 0);
        send_frame(5000, 0, 1, 0, 0);
        send_frame(800, 1, 1, 0, 1);
        read_check("R7 rx off no jabber", 0);
        read_check("R7 rx off octets unchanged", 1);
    endtask

    task automatic t_jab_clear_sat();
        read_check("R10 clear before sat", 0);
        for (int i = 0; i < 3; i++) send_frame(2000, 0, 1, 1, 0);
        read_check("R10 jabber read returns 3", 0);
        read_check("R10 jabber cleared", 0);
        @(negedge clk);
        for (int i = 0; i < 260; i++) begin
            drive_frame(2000, 0, 1, 1, 0);
            @(negedge clk);
            model_frame(2000, 0, 1, 1, 0);
        end
        frm_valid = 1'b0;
        check("R11 model at max", exp_jab, JAB_MAX);
        read_check("R11 jabber saturates", 0);
        read_check("R11 octet lo after burst", 1);
        read_check("R11 octet hi after burst", 2);
    endtask

    task automatic t_same_cycle();
        send_frame(2000, 0, 1, 1, 0);
        send_frame(2000, 0, 1, 1, 0);
        read_with_frame("R12 jabber read sees old", 0, 2000, 0, 0);
        check("R12 model keeps new frame", exp_jab, 1);
        read_check("R12 jabber holds new frame", 0);
        read_with_frame("R12 octet hi read sees old", 2, 777, 1, 0);
        read_check("R12 octet lo holds new frame", 1);
        read_check("R12 octet hi after new frame", 2);
    endtask

    task automatic t_oct_sat();
        @(negedge clk);
        for (int i = 0; i < 16400; i++) begin
            drive_frame((1 << LW) - 1, 1, 1, 1, 1);
            @(negedge clk);
            model_frame((1 << LW) - 1, 1, 1, 1, 1);
        end
        frm_valid = 1'b0;
        check("R8 model saturated", exp_oct, OCT_MAX);
        read_check("R8 octet lo all ones", 1);
        read_check("R8 octet hi top bits", 2);
        read_check("R9 octet lo zero after sat clear", 1);
        read_check("R4 long good crc no jabber", 0);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_std_limit();
        t_long_limit();
        t_qualifiers();
        t_octets();
        t_rx_off();
        t_jab_clear_sat();
        t_same_cycle();
        t_oct_sat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule